// File: doc/BRIEF.md
# Phase Voltage Routing Crossbar

This block sits between the voltage sample front end and three per-phase computation paths of a poly-phase metering datapath. Each path normally works on its own phase voltage. A configuration word can point any path at the voltage of another phase. This is useful for test and for installations with swapped wiring. Each path always keeps its own phase current, so only the voltage half of each voltage/current pair is rerouted.

The three voltage samples and the three current samples arrive together and are qualified by one valid strobe. Configuration is written through a simple write-enable/data port. The routed pairs leave the block registered, with one cycle of latency and a matching valid. Between valid samples the outputs hold the last routed pair.

Top module: `vroute_xbar`

## Requirements
- R1: While reset is held and after it is released, every select field is 00 (each path uses its own phase voltage), all voltage/current outputs are zero and `out_valid` is 0 until the first sample.
- R2: Path A's source follows `cfg_wdata[9:8]`: 00 gives voltage A, 01 gives voltage B, 10 gives voltage C.
- R3: Path B's source follows `cfg_wdata[11:10]`: 00 gives voltage B, 01 gives voltage C, 10 gives voltage A.
- R4: Path C's source follows `cfg_wdata[13:12]`: 00 gives voltage C, 01 gives voltage A, 10 gives voltage B.
- R5: The code 11 in any field behaves exactly like 00 for that path (own phase voltage).
- R6: Each path's current output is always its own phase current, whatever the select codes are.
- R7: A sample presented with `in_valid` high in cycle t appears on the outputs after the next rising edge, with `out_valid` high for exactly that one cycle. `out_valid` is `in_valid` delayed by one cycle.
- R8: While `in_valid` is low, all voltage and current outputs hold their previous values.
- R9: A configuration write applies to the first valid sample in any later cycle. A sample that is valid in the same cycle as the write is routed with the previous configuration. Bits of `cfg_wdata` outside [13:8] have no effect.
- R10: One source voltage may feed several paths at once, including all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word; select fields at [9:8], [11:10], [13:12] |
| in_valid | input | 1 | Qualifies the six input samples |
| v_a_in | input | 24 | Phase A voltage sample (signed) |
| v_b_in | input | 24 | Phase B voltage sample (signed) |
| v_c_in | input | 24 | Phase C voltage sample (signed) |
| i_a_in | input | 24 | Phase A current sample (signed) |
| i_b_in | input | 24 | Phase B current sample (signed) |
| i_c_in | input | 24 | Phase C current sample (signed) |
| out_valid | output | 1 | Routed samples valid |
| path_a_v | output | 24 | Voltage routed to path A |
| path_a_i | output | 24 | Current of path A |
| path_b_v | output | 24 | Voltage routed to path B |
| path_b_i | output | 24 | Current of path B |
| path_c_v | output | 24 | Voltage routed to path C |
| path_c_i | output | 24 | Current of path C |

## Verification
The embedded properties check several rules on every cycle. The select fields clear under reset, and a write loads the field bits. The valid output trails the input by one cycle. Each current is its own phase's value, the reserved code yields the own voltage, and the outputs hold while no sample arrives. The directed scenarios cover what the properties do not. They sweep every code of every field against the encoding table and send the same source to several paths. They also show that a write landing together with a sample leaves that sample on the old routing, and that bits outside the fields change nothing.

// File: rtl/vroute_pkg.sv
// Shared constants, types and the source-decode function of the
// phase voltage routing crossbar.
// Assumes exactly three phases and two-bit select codes.
package vroute_pkg;
    localparam int NUM_PH = 3;
    localparam int SEL_W  = 2;

    typedef logic [SEL_W-1:0] sel_t;

    // Source phase for a path: code 11 means own phase; otherwise the
    // code rotates forward from the path's own index.
    function automatic logic [1:0] src_of(input int path, input sel_t code);
        int s;
        if (code == 2'b11) s = path;
        else               s = (path + int'(code)) % NUM_PH;
        return 2'(s);
    endfunction
endpackage

// File: rtl/vroute_cfg.sv
// Configuration register of the crossbar: holds one select code per
// path, loaded from fixed bit positions of the written word.
// Assumes the field block starts at SEL_LSB and fits inside CFG_W.
module vroute_cfg
    import vroute_pkg::*;
#(
    parameter int CFG_W   = 16,
    parameter int SEL_LSB = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CFG_W-1:0]             wdata,
    output logic [NUM_PH-1:0][SEL_W-1:0] sel
);
    localparam int SEL_MSB = SEL_LSB + NUM_PH*SEL_W - 1;

    logic [NUM_PH-1:0][SEL_W-1:0] sel_q;
    logic unused_cfg_bits;

    // Bits outside the select block are deliberately dropped.
    assign unused_cfg_bits = ^{wdata[CFG_W-1:SEL_MSB+1], wdata[SEL_LSB-1:0]};

    // Holds the select codes; clears to own-phase routing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_en) sel_q <= wdata[SEL_MSB:SEL_LSB];
    end

    assign sel = sel_q;

    // R1
    sel_reset_chk: assert property (@(posedge clk) !rst_n |=> (sel_q == '0));
    // R9
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_q == $past(wdata[SEL_MSB:SEL_LSB])));
endmodule

// File: rtl/vroute_path.sv
// One computation-path output stage: picks the voltage named by its
// select code and registers it with the path's own current. Loads only
// on valid samples and holds otherwise.
// Assumes the select code is stable during the cycle it is used.
module vroute_path
    import vroute_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int PATH_IDX = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  sel_t                          sel,
    input  logic [NUM_PH-1:0][DATA_W-1:0] v_all,
    input  logic [DATA_W-1:0]             i_own,
    output logic [DATA_W-1:0]             v_q,
    output logic [DATA_W-1:0]             i_q
);
    logic [1:0]        src;
    logic [DATA_W-1:0] v_pick;

    // Decodes the rotated code into a source phase index.
    always_comb src = src_of(PATH_IDX, sel);

    // Selects the source voltage from the three phases.
    always_comb begin
        v_pick = v_all[0];
        for (int k = 0; k < NUM_PH; k++)
            if (src == 2'(k)) v_pick = v_all[k];
    end

    // Registers the routed pair on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            i_q <= '0;
        end else if (in_valid) begin
            v_q <= v_pick;
            i_q <= i_own;
        end
    end

    // R5
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == 2'b11) |=> (v_q == $past(v_all[PATH_IDX])));
    // R6
    own_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (i_q == $past(i_own)));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(v_q) && $stable(i_q)));
endmodule

// File: rtl/vroute_xbar.sv
// Phase voltage routing crossbar top: a configuration register plus
// one output stage per computation path, with a delayed valid.
// Assumes all six input samples share the in_valid strobe.
module vroute_xbar
    import vroute_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int CFG_W   = 16,
    parameter int SEL_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] v_a_in,
    input  logic [DATA_W-1:0] v_b_in,
    input  logic [DATA_W-1:0] v_c_in,
    input  logic [DATA_W-1:0] i_a_in,
    input  logic [DATA_W-1:0] i_b_in,
    input  logic [DATA_W-1:0] i_c_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] path_a_v,
    output logic [DATA_W-1:0] path_a_i,
    output logic [DATA_W-1:0] path_b_v,
    output logic [DATA_W-1:0] path_b_i,
    output logic [DATA_W-1:0] path_c_v,
    output logic [DATA_W-1:0] path_c_i
);
    logic [NUM_PH-1:0][SEL_W-1:0]  sel;
    logic [NUM_PH-1:0][DATA_W-1:0] v_all, i_all, v_out, i_out;
    logic                          valid_q;

    assign v_all = {v_c_in, v_b_in, v_a_in};
    assign i_all = {i_c_in, i_b_in, i_a_in};

    vroute_cfg #(.CFG_W(CFG_W), .SEL_LSB(SEL_LSB)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata), .sel(sel)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_path
        vroute_path #(.DATA_W(DATA_W), .PATH_IDX(p)) path_i (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel(sel[p]),
            .v_all(v_all), .i_own(i_all[p]), .v_q(v_out[p]), .i_q(i_out[p])
        );
    end

    // Delays the sample strobe to match the registered data.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    assign out_valid = valid_q;
    assign path_a_v  = v_out[0];
    assign path_a_i  = i_out[0];
    assign path_b_v  = v_out[1];
    assign path_b_i  = i_out[1];
    assign path_c_v  = v_out[2];
    assign path_c_i  = i_out[2];

    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && path_a_v == '0 && path_b_i == '0 && path_c_v == '0));
endmodule

// File: tb/vroute_xbar_tb_top.sv
module vroute_xbar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [23:0] vin [3];
    logic [23:0] iin [3];
    logic        out_valid;
    logic [23:0] vout [3];
    logic [23:0] iout [3];
    logic [23:0] pav, pai, pbv, pbi, pcv, pci;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vroute_xbar dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid),
        .v_a_in(vin[0]), .v_b_in(vin[1]), .v_c_in(vin[2]),
        .i_a_in(iin[0]), .i_b_in(iin[1]), .i_c_in(iin[2]),
        .out_valid(out_valid),
        .path_a_v(pav), .path_a_i(pai), .path_b_v(pbv),
        .path_b_i(pbi), .path_c_v(pcv), .path_c_i(pci)
    );

    always_comb begin
        vout[0] = pav; vout[1] = pbv; vout[2] = pcv;
        iout[0] = pai; iout[1] = pbi; iout[2] = pci;
    end

    // Expected source from the requirement tables (R2, R3, R4, R5).
    function automatic int exp_src(input int path, input int code);
        case (path)
            0: case (code) 1: return 1; 2: return 2; default: return 0; endcase
            1: case (code) 1: return 2; 2: return 0; default: return 1; endcase
            default: case (code) 1: return 0; 2: return 1; default: return 2; endcase
        endcase
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic load(input int seed);
        for (int p = 0; p < 3; p++) begin
            vin[p] = 24'(32'h100000 * (p + 1) + seed * 16 + 1);
            iin[p] = 24'(32'h800000 + 32'h010000 * (p + 1) + seed);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic send(input int seed);
        @(negedge clk);
        load(seed);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_routes(input string tag, input int c0, input int c1, input int c2);
        int codes [3];
        codes[0] = c0; codes[1] = c1; codes[2] = c2;
        chk("R7 out_valid", 24'(out_valid), 24'd1);
        for (int p = 0; p < 3; p++) begin
            chk(tag, vout[p], vin[exp_src(p, codes[p])]);
            chk("R6 current", iout[p], iin[p]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 24'(out_valid), 24'd0);
        for (int p = 0; p < 3; p++) begin
            chk("R1 v", vout[p], 24'd0);
            chk("R1 i", iout[p], 24'd0);
        end
        rst_n = 1'b1;
        send(1);
        check_routes("R1 default", 0, 0, 0);
    endtask

    task automatic t_codes();
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 4; c++) begin
                int cc [3];
                string tag;
                cc[0] = 0; cc[1] = 0; cc[2] = 0; cc[p] = c;
                tag = (c == 3) ? "R5" : (p == 0) ? "R2" : (p == 1) ? "R3" : "R4";
                wr_cfg(16'(c << (8 + 2 * p)));
                send(p * 4 + c + 2);
                check_routes(tag, cc[0], cc[1], cc[2]);
            end
        end
    endtask

    task automatic t_shared();
        wr_cfg(16'((2 << 10) | (1 << 12)));
        send(20);
        check_routes("R10 all from A", 0, 2, 1);
        chk("R10 B gets A", pbv, vin[0]);
        chk("R10 C gets A", pcv, vin[0]);
        wr_cfg(16'((2 << 8) | (2 << 10) | (2 << 12)));
        send(21);
        check_routes("R10 rotate", 2, 2, 2);
    endtask

    task automatic t_latency_hold();
        logic [23:0] sv [3];
        logic [23:0] si [3];
        send(30);
        @(negedge clk);
        chk("R7 valid drops", 24'(out_valid), 24'd0);
        for (int p = 0; p < 3; p++) begin sv[p] = vout[p]; si[p] = iout[p]; end
        load(31);
        repeat (3) @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            chk("R8 v hold", vout[p], sv[p]);
            chk("R8 i hold", iout[p], si[p]);
        end
    endtask

    task automatic t_concurrent();
        wr_cfg(16'h0000);
        @(negedge clk);
        load(40);
        in_valid = 1'b1; cfg_wr_en = 1'b1; cfg_wdata = 16'((1 << 8) | (1 << 10) | (1 << 12));
        @(negedge clk);
        in_valid = 1'b0; cfg_wr_en = 1'b0;
        check_routes("R9 old cfg for same-cycle sample", 0, 0, 0);
        send(41);
        check_routes("R9 new cfg next sample", 1, 1, 1);
        wr_cfg(16'hC0FF);
        send(42);
        check_routes("R9 bits outside fields ignored", 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        load(0);
        t_reset();
        t_codes();
        t_shared();
        t_latency_hold();
        t_concurrent();
        done = 1;
        summary();
        $finish;
    end
endmodule